// File: doc/BRIEF.md
# Host Adapter Vendor Command Processor

This block sits behind the host-side command register of a storage host adapter. It takes a stream of bytes, one per cycle when `cmd_valid` is high. The first byte of a command is an opcode. The block works out how many parameter bytes that opcode carries, collects them, and then executes the command in one cycle against a local 256-byte configuration store and a few state registers.

Results leave the block in three ways. Reply bytes are handed out one at a time over a valid/ready pair. An interrupt-status code and an invalid-command flag are held on outputs. The configuration state is also driven on outputs: lock flag, ROM bank, shadow-memory mode, mailbox count and address, and a pending fast-request count.

One opcode, 0x82, is a fast command. It skips parameter collection and only bumps a request counter. The parameter `STORE_EN` builds the block without a working configuration store. In that build both store opcodes are rejected.

Top module: `vcmd_engine`

## Requirements
- R1: After reset there is no reply pending, `intr_status` is 0x00, `invalid_cmd` is 0, `init_pending` is 1, and the following are all 0: lock flag, ROM bank, shadow mode, `mbox_ready`, mailbox count, mailbox address and `fast_req_count`.
- R2: Execution happens at the clock edge after the edge that accepts the last parameter byte. An opcode without parameters executes at the edge after its own acceptance. Execution results are not visible before that edge.
- R3: Opcode 0x22 takes 35 parameter bytes: argument, length L, offset F, then 32 data bytes. Data byte i is written to store address (F+i) mod 256 only when i < L. The command produces no reply.
- R4: Opcode 0x23 takes 3 parameter bytes: argument, length L, offset F. It replies with L bytes, where byte i is the store content at (F+i) mod 256.
- R5: With `STORE_EN`=0, opcodes 0x22 and 0x23 set `invalid_cmd` and produce no reply.
- R6: Opcode 0x24 takes 1 parameter byte. Bits [1:0] of that byte become `shadow_mode`, with bit 0 as write enable and bit 1 as read enable. `intr_status` becomes 0x04.
- R7: Opcode 0x25 takes 4 parameter bytes: a count, then a 24-bit address sent most significant byte first. It loads `mbox_count` and `mbox_addr`, sets `mbox_ready`, clears `init_pending`, and produces no reply.
- R8: Opcode 0x26 sets `rom_bank` to 0 and opcode 0x27 sets it to 1. Neither produces a reply.
- R9: Opcode 0x28 replies with two bytes: 0x08 first, then the lock flag in bit 0 with the upper bits zero.
- R10: Opcode 0x29 takes 2 parameter bytes. The lock flag takes bit 0 of the first byte only when the second byte equals the current lock flag. Otherwise the lock flag is unchanged.
- R11: Opcode 0x2C replies with a single 0x00. Any other opcode not listed sets `invalid_cmd` and produces no reply. Accepting any opcode byte clears both `invalid_cmd` and `intr_status`.
- R12: Opcode 0x82, when received as an opcode, increments `fast_req_count` at the edge that accepts it. It collects no parameters, and the next byte is treated as an opcode.
- R13: A reply byte stays on `rsp_data` until it is taken with `rsp_ready`. A command byte that arrives while reply bytes remain discards all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command or parameter byte present this cycle |
| cmd_data | input | 8 | Command or parameter byte |
| rsp_valid | output | 1 | Reply byte available |
| rsp_ready | input | 1 | Host takes the reply byte |
| rsp_data | output | 8 | Reply byte |
| intr_status | output | 8 | Interrupt-status code |
| invalid_cmd | output | 1 | Last command was rejected |
| init_pending | output | 1 | Mailbox not yet initialised |
| lock_flag | output | 1 | Current lock flag |
| rom_bank | output | 1 | Selected ROM bank |
| shadow_mode | output | 2 | Shadow memory enables: bit 0 write, bit 1 read |
| mbox_ready | output | 1 | Mailbox initialised |
| mbox_count | output | 8 | Mailbox entry count |
| mbox_addr | output | 24 | Mailbox base address |
| fast_req_count | output | REQ_W | Pending fast request count |

## Verification
The bench writes a block that crosses store address 0xFF. A design that did not wrap the address would return the wrong bytes after 0xFF. The bench also issues a write whose length is shorter than the data it carries. A design that ignored the length would overwrite the neighbouring bytes that were loaded earlier.

The lock handshake is exercised with both a matching and a mismatching echo byte. A design that compared the wrong byte, or did not compare at all, would flip the lock when it should not.

Effects are sampled one cycle after the last parameter, and a reply is abandoned partway through by a new command. A design that executed early would show its results a cycle too soon. A design that kept stale reply bytes would hand them out in front of the new reply.

// File: rtl/vcmd_engine.sv
module vcmd_engine #(
  parameter bit STORE_EN = 1'b1,
  parameter int DATA_MAX = 32,
  parameter int REQ_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic [7:0]       intr_status,
  output logic             invalid_cmd,
  output logic             init_pending,
  output logic             lock_flag,
  output logic             rom_bank,
  output logic [1:0]       shadow_mode,
  output logic             mbox_ready,
  output logic [7:0]       mbox_count,
  output logic [23:0]      mbox_addr,
  output logic [REQ_W-1:0] fast_req_count
);
  localparam int WR_PARAMS = DATA_MAX + 3;
  localparam int CNT_W     = $clog2(WR_PARAMS + 1);

  typedef enum logic [1:0] {S_IDLE, S_PARAM, S_EXEC} st_t;
  st_t st;

  logic [7:0]       op;
  logic [CNT_W-1:0] need, got;
  logic [7:0]       p0, p1, p2, p3;
  logic [7:0]       store [256];
  logic [7:0]       rsp_left, rsp_ptr, rsp_b0, rsp_b1;
  logic             rsp_src;

  function automatic logic [CNT_W-1:0] param_need(input logic [7:0] o);
    case (o)
      8'h22:   return CNT_W'(WR_PARAMS);
      8'h23:   return CNT_W'(3);
      8'h24:   return CNT_W'(1);
      8'h25:   return CNT_W'(4);
      8'h29:   return CNT_W'(2);
      default: return '0;
    endcase
  endfunction

  wire              idle_now = (st == S_IDLE);
  wire              exec_now = (st == S_EXEC);
  wire [CNT_W-1:0]  need_now = param_need(cmd_data);
  wire [CNT_W-1:0]  didx     = got - CNT_W'(3);
  wire [7:0]        wr_addr  = p2 + 8'(didx);
  wire              store_wr = STORE_EN && cmd_valid && (st == S_PARAM) && (op == 8'h22)
                               && (32'(got) >= 32'd3) && (32'(didx) < 32'(p1));

  assign rsp_valid = (rsp_left != 8'd0);
  assign rsp_data  = rsp_src ? store[rsp_ptr] : (rsp_ptr[0] ? rsp_b1 : rsp_b0);

  always_ff @(posedge clk)
    if (store_wr) store[wr_addr] <= cmd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op <= '0; need <= '0; got <= '0;
      p0 <= '0; p1 <= '0; p2 <= '0; p3 <= '0;
      rsp_left <= '0; rsp_ptr <= '0; rsp_b0 <= '0; rsp_b1 <= '0; rsp_src <= 1'b0;
      intr_status <= '0; invalid_cmd <= 1'b0; init_pending <= 1'b1;
      lock_flag <= 1'b0; rom_bank <= 1'b0; shadow_mode <= '0;
      mbox_ready <= 1'b0; mbox_count <= '0; mbox_addr <= '0;
      fast_req_count <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            invalid_cmd <= 1'b0;
            intr_status <= '0;
            rsp_left    <= '0;
            if (cmd_data == 8'h82) begin
              fast_req_count <= fast_req_count + 1'b1;
            end else begin
              op   <= cmd_data;
              need <= need_now;
              got  <= '0;
              st   <= (need_now == '0) ? S_EXEC : S_PARAM;
            end
          end else if (rsp_valid && rsp_ready) begin
            rsp_ptr  <= rsp_ptr + 8'd1;
            rsp_left <= rsp_left - 8'd1;
          end
        end
        S_PARAM: begin
          if (cmd_valid) begin
            case (got)
              CNT_W'(0): p0 <= cmd_data;
              CNT_W'(1): p1 <= cmd_data;
              CNT_W'(2): p2 <= cmd_data;
              CNT_W'(3): p3 <= cmd_data;
              default: ;
            endcase
            got <= got + CNT_W'(1);
            if (got == need - CNT_W'(1)) st <= S_EXEC;
          end
        end
        default: begin
          st <= S_IDLE;
          case (op)
            8'h22: if (!STORE_EN) invalid_cmd <= 1'b1;
            8'h23: begin
              if (!STORE_EN) invalid_cmd <= 1'b1;
              else begin
                rsp_left <= p1;
                rsp_ptr  <= p2;
                rsp_src  <= 1'b1;
              end
            end
            8'h24: begin
              shadow_mode <= p0[1:0];
              intr_status <= 8'h04;
            end
            8'h25: begin
              mbox_count   <= p0;
              mbox_addr    <= {p1, p2, p3};
              mbox_ready   <= 1'b1;
              init_pending <= 1'b0;
            end
            8'h26: rom_bank <= 1'b0;
            8'h27: rom_bank <= 1'b1;
            8'h28: begin
              rsp_b0 <= 8'h08; rsp_b1 <= {7'b0, lock_flag};
              rsp_left <= 8'd2; rsp_ptr <= '0; rsp_src <= 1'b0;
            end
            8'h29: if (p1 == {7'b0, lock_flag}) lock_flag <= p0[0];
            8'h2C: begin
              rsp_b0 <= 8'h00;
              rsp_left <= 8'd1; rsp_ptr <= '0; rsp_src <= 1'b0;
            end
            default: invalid_cmd <= 1'b1;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/vcmd_engine_chk.sv
module vcmd_engine_chk #(parameter int REQ_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_data,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic [7:0]       intr_status,
  input logic             lock_flag,
  input logic             rom_bank,
  input logic             init_pending,
  input logic [REQ_W-1:0] fast_req_count,
  input logic             idle_now,
  input logic             exec_now
);
  assert_intr_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_status == 8'h00) || (intr_status == 8'h04));

  assert_lock_on_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_flag) |-> $past(exec_now));

  assert_bank_on_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_bank) |-> $past(exec_now));

  assert_init_on_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_pending) |-> $past(exec_now));

  assert_fast_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && cmd_valid && cmd_data == 8'h82) |=>
      (fast_req_count == REQ_W'($past(fast_req_count) + 1'b1)));

  assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !cmd_valid) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && cmd_valid) |=> !rsp_valid);
endmodule

bind vcmd_engine vcmd_engine_chk #(.REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .intr_status(intr_status), .lock_flag(lock_flag), .rom_bank(rom_bank),
  .init_pending(init_pending), .fast_req_count(fast_req_count),
  .idle_now(idle_now), .exec_now(exec_now)
);

// File: tb/test_vcmd_engine.sv
module test_vcmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic rsp_ready = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  logic rsp_valid, invalid_cmd, init_pending, lock_flag, rom_bank, mbox_ready;
  logic [7:0] rsp_data, intr_status, mbox_count;
  logic [1:0] shadow_mode;
  logic [23:0] mbox_addr;
  logic [7:0] fast_req_count;

  logic n_rsp_valid, n_invalid, n_init, n_lock, n_bank, n_mready;
  logic [7:0] n_rsp_data, n_intr, n_mcount;
  logic [1:0] n_shadow;
  logic [23:0] n_maddr;
  logic [7:0] n_fast;

  vcmd_engine i_vcmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .intr_status(intr_status), .invalid_cmd(invalid_cmd), .init_pending(init_pending),
    .lock_flag(lock_flag), .rom_bank(rom_bank), .shadow_mode(shadow_mode),
    .mbox_ready(mbox_ready), .mbox_count(mbox_count), .mbox_addr(mbox_addr),
    .fast_req_count(fast_req_count));

  vcmd_engine #(.STORE_EN(1'b0)) i_vcmd_engine_nostore (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rsp_valid(n_rsp_valid), .rsp_ready(rsp_ready), .rsp_data(n_rsp_data),
    .intr_status(n_intr), .invalid_cmd(n_invalid), .init_pending(n_init),
    .lock_flag(n_lock), .rom_bank(n_bank), .shadow_mode(n_shadow),
    .mbox_ready(n_mready), .mbox_count(n_mcount), .mbox_addr(n_maddr),
    .fast_req_count(n_fast));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_data = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(input string tag, input logic [7:0] exp);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " rsp_data"}, 32'(rsp_data), 32'(exp));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic store_write(input logic [7:0] len, input logic [7:0] off, input logic [7:0] base);
    put(8'h22); put(8'h00); put(len); put(off);
    for (int i = 0; i < 32; i++) put(base + 8'(i));
    idle(2);
  endtask

  task automatic store_read(input logic [7:0] len, input logic [7:0] off);
    put(8'h23); put(8'h00); put(len); put(off);
    idle(1);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 intr", 32'(intr_status), 0);
    chk("R1 invalid", 32'(invalid_cmd), 0);
    chk("R1 init", 32'(init_pending), 1);
    chk("R1 lock", 32'(lock_flag), 0);
    chk("R1 bank", 32'(rom_bank), 0);
    chk("R1 shadow", 32'(shadow_mode), 0);
    chk("R1 mbox", {mbox_addr, mbox_count}, 0);
    chk("R1 mready", 32'(mbox_ready), 0);
    chk("R1 fast", 32'(fast_req_count), 0);
  endtask

  task automatic t_timing;
    put(8'h27);
    chk("R2 bank before exec", 32'(rom_bank), 0);
    idle(1);
    chk("R8 bank 1", 32'(rom_bank), 1);
    chk("R8 no reply", 32'(rsp_valid), 0);
    put(8'h26); idle(1);
    chk("R8 bank 0", 32'(rom_bank), 0);
    put(8'h24); put(8'h03);
    chk("R2 shadow before exec", 32'(shadow_mode), 0);
    idle(1);
    chk("R6 shadow", 32'(shadow_mode), 3);
    chk("R6 intr", 32'(intr_status), 32'h04);
    put(8'h24); put(8'h06); idle(1);
    chk("R6 shadow bits", 32'(shadow_mode), 2);
    put(8'h26);
    chk("R11 intr cleared", 32'(intr_status), 0);
    idle(1);
  endtask

  task automatic t_store;
    store_write(8'd32, 8'h10, 8'h11);
    chk("R3 no reply", 32'(rsp_valid), 0);
    store_write(8'd3, 8'h10, 8'hA0);
    store_read(8'd5, 8'h10);
    pop("R4 b0", 8'hA0); pop("R4 b1", 8'hA1); pop("R4 b2", 8'hA2);
    pop("R3 len limit b3", 8'h14); pop("R3 len limit b4", 8'h15);
    chk("R4 reply end", 32'(rsp_valid), 0);
    store_write(8'd5, 8'hFD, 8'h40);
    store_read(8'd5, 8'hFD);
    pop("R4 wrap FD", 8'h40); pop("R4 wrap FE", 8'h41); pop("R4 wrap FF", 8'h42);
    pop("R3 wrap 00", 8'h43); pop("R3 wrap 01", 8'h44);
    store_read(8'd0, 8'h00);
    chk("R4 zero length", 32'(rsp_valid), 0);
  endtask

  task automatic t_discard;
    store_read(8'd4, 8'h10);
    pop("R13 first", 8'hA0);
    chk("R13 hold", 32'(rsp_data), 32'hA1);
    put(8'h28);
    chk("R13 discarded", 32'(rsp_valid), 0);
    idle(1);
    pop("R13 new reply", 8'h08);
    pop("R9 lock byte", 8'h00);
    chk("R13 end", 32'(rsp_valid), 0);
  endtask

  task automatic t_lock;
    put(8'h29); put(8'h01); put(8'h01); idle(1);
    chk("R10 mismatch ignored", 32'(lock_flag), 0);
    put(8'h29); put(8'h01); put(8'h00); idle(1);
    chk("R10 lock set", 32'(lock_flag), 1);
    put(8'h28); idle(1);
    pop("R9 const", 8'h08); pop("R9 lock 1", 8'h01);
    put(8'h29); put(8'h00); put(8'h00); idle(1);
    chk("R10 stale echo", 32'(lock_flag), 1);
    put(8'h29); put(8'hFE); put(8'h01); idle(1);
    chk("R10 lock clear", 32'(lock_flag), 0);
  endtask

  task automatic t_mbox;
    put(8'h25); put(8'h04); put(8'h12); put(8'h34); put(8'h56);
    chk("R7 init before exec", 32'(init_pending), 1);
    idle(1);
    chk("R7 count", 32'(mbox_count), 4);
    chk("R7 addr", 32'(mbox_addr), 32'h123456);
    chk("R7 ready", 32'(mbox_ready), 1);
    chk("R7 init", 32'(init_pending), 0);
    chk("R7 no reply", 32'(rsp_valid), 0);
  endtask

  task automatic t_misc;
    put(8'h2C); idle(1);
    pop("R11 2C", 8'h00);
    chk("R11 single", 32'(rsp_valid), 0);
    put(8'h55); idle(1);
    chk("R11 unknown invalid", 32'(invalid_cmd), 1);
    chk("R11 unknown no reply", 32'(rsp_valid), 0);
    put(8'h26);
    chk("R11 invalid cleared", 32'(invalid_cmd), 0);
    idle(1);
  endtask

  task automatic t_fast;
    logic [7:0] f0;
    f0 = fast_req_count;
    put(8'h82);
    chk("R12 inc", 32'(fast_req_count), 32'(f0 + 8'd1));
    put(8'h82);
    chk("R12 inc2", 32'(fast_req_count), 32'(f0 + 8'd2));
    put(8'h27); idle(1);
    chk("R12 next is opcode", 32'(rom_bank), 1);
    put(8'h26); idle(1);
  endtask

  task automatic t_nostore;
    store_write(8'd2, 8'h00, 8'h77);
    chk("R5 write invalid", 32'(n_invalid), 1);
    chk("R5 write no reply", 32'(n_rsp_valid), 0);
    store_read(8'd2, 8'h00);
    chk("R5 read invalid", 32'(n_invalid), 1);
    chk("R5 read no reply", 32'(n_rsp_valid), 0);
    chk("R5 store build valid", 32'(invalid_cmd), 0);
    pop("R4 main store", 8'h77);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_timing;
    t_store;
    t_discard;
    t_lock;
    t_mbox;
    t_misc;
    t_fast;
    t_nostore;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule